// File: doc/BRIEF.md
# Dual-Clock Parity FIFO with Retransmit

This block is an 18-bit by 512-word first-in first-out buffer between two unrelated clock domains. A producer pushes words on its own free-running clock whenever its write enable is high. A consumer pulls words on a second clock with a separate read enable. The read word comes out of a register. Both ports may run at the same time. Each side works out its own view of the fill level from a Gray-coded copy of the other side's pointer, which passes through a two-flop synchroniser.

Status leaves on three outputs. `bound_flag` means "empty or full", and `near_flag` means "almost empty or almost full". `half_flag` tells the two ends apart: it is low near the empty end and high near the full end.

A small program register is loaded through the data input. It holds the two almost-flag distances and the parity mode. In generate mode the block overwrites bits 8 and 17 with even parity of their bytes as words are stored. In check mode it raises one error bit per byte next to the read word. A retransmit pulse moves the read position back to the first word written since reset, so that block of data can be read again.

Top module: `dcfifo_par`

## Requirements
- R1: Words are accepted on a rising `wclk` edge when `wr_en` is high. Each accepted word appears on `dout` in write order. A read is accepted on a rising `rclk` edge when `rd_en` is high and the FIFO is not empty, and `dout` and `par_err` update at that same edge.
- R2: A write attempted while the FIFO holds 512 words is ignored. The stored words and their order are unchanged.
- R3: A read attempted while the FIFO is empty is ignored. `dout` keeps the last word read, and the FIFO stays empty.
- R4: `bound_flag` is 1 when the stored count is 0 or 512, and 0 otherwise.
- R5: `half_flag` is 1 when the stored count is at least 257, and 0 otherwise.
- R6: `near_flag` is 1 when the count is at or below the almost-empty distance, or at or above 512 minus the almost-full distance. Both distances are 8 after reset.
- R7: A program write is an `wclk` edge with `cfg_wr` high, and it stores no word. `din[17:16]` selects the field and the FIFO must be empty, otherwise the write has no effect. Selector 0 loads the almost-empty distance from `din[8:0]`. Selector 1 loads the almost-full distance from `din[8:0]`. Selector 2 loads the parity mode: `din[0]` turns on generation and `din[1]` turns on checking.
- R8: With generation on, each stored word has bit 8 replaced by the XOR of bits 7..0 and bit 17 replaced by the XOR of bits 16..9.
- R9: With checking on, `par_err[0]` is the XOR of bits 8..0 of the word read and `par_err[1]` is the XOR of bits 17..9. With checking off, both bits are 0.
- R10: A retransmit pulse on `rt`, given while writes are idle and no more than 512 words have been written since reset, makes the following reads start again at the first word written since reset. The flags then reflect all of those words as stored. `rt` takes priority over a read in the same cycle.
- R11: Driving `rst_n` low empties the FIFO, clears `dout` and `par_err`, restores both distances to 8 and turns parity off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| wr_en | input | 1 | Store `din` on the next `wclk` rise |
| cfg_wr | input | 1 | Treat `din` as a program-register write |
| din | input | 18 | Write data, or the program selector and value |
| rd_en | input | 1 | Pull one word on the next `rclk` rise |
| rt | input | 1 | Rewind the read position to the first word |
| dout | output | 18 | Registered read data |
| par_err | output | 2 | Per-byte parity error for the word on `dout` |
| bound_flag | output | 1 | Empty or full |
| near_flag | output | 1 | Almost empty or almost full |
| half_flag | output | 1 | At least 257 words stored |

## Verification
Phased fills stop on both sides of every threshold: 8/9 words, 256/257, 503/504, and both sides of the reprogrammed levels. These stops separate the near-empty, near-full and half-full flags and show that an off-by-one appears at exactly one count. A full buffer followed by an extra write, and an empty buffer followed by an extra read, show whether a pointer moves past its bound. A seeded random stream with both enables toggling on clocks of different period tests the pointer crossing, because any lost or repeated word breaks the order check. Random words in check mode, with no generated parity, give each byte both good and bad parity. A replay after rewind shows the read pointer going back to the first word.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
   // program register field selector carried in the two top data bits
   typedef enum logic [1:0] {
      SEL_AE_LVL = 2'd0,
      SEL_AF_LVL = 2'd1,
      SEL_PARITY = 2'd2,
      SEL_NONE   = 2'd3
   } cfg_sel_e;

   typedef struct packed {
      logic chk;
      logic gen;
   } par_mode_t;

   localparam int CFG_SEL_W = 2;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= gray_in;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   // Gray to binary: each bit is the XOR of itself and all higher bits
   for (genvar b = 0; b < W; b++) begin : g_bin
      assign bin_out[b] = ^(stg[STAGES-1] >> b);
   end
endmodule

// File: rtl/dcf_par.sv
`timescale 1ns/1ps
module dcf_par #(
   parameter int DATA_W = 18,
   parameter int BYTE_W = 9,
   parameter bit PAR_EN = 1'b1
)(
   input  logic                       gen_en,
   input  logic                       chk_en,
   input  logic [DATA_W-1:0]          wr_in,
   output logic [DATA_W-1:0]          wr_out,
   input  logic [DATA_W-1:0]          rd_word,
   output logic [DATA_W/BYTE_W-1:0]   err
);
   localparam int NBYTE = DATA_W / BYTE_W;

   if (PAR_EN) begin : g_par
      for (genvar b = 0; b < NBYTE; b++) begin : g_byte
         localparam int LO = b * BYTE_W;
         localparam int HI = LO + BYTE_W - 1;
         assign wr_out[HI-1:LO] = wr_in[HI-1:LO];
         assign wr_out[HI]      = gen_en ? ^wr_in[HI-1:LO] : wr_in[HI];
         assign err[b]          = chk_en & (^rd_word[HI:LO]);
      end
   end else begin : g_nopar
      logic unused_par;
      assign unused_par = ^{gen_en, chk_en, rd_word};
      assign wr_out     = wr_in;
      assign err        = '0;
   end
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl
   import dcf_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int ALM_DEFAULT = 8
)(
   input  logic                 wclk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 cfg_wr,
   input  logic [CFG_SEL_W-1:0] cfg_sel,
   input  logic [ADDR_W-1:0]    cfg_val,
   input  logic [ADDR_W:0]      rptr_s,
   output logic [ADDR_W:0]      wptr,
   output logic [ADDR_W:0]      wgray,
   output logic                 mem_we,
   output logic                 full_w,
   output logic                 alm_f,
   output logic                 half_w,
   output logic [ADDR_W-1:0]    ae_lvl,
   output par_mode_t            mode
);
   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
   localparam logic [PW-1:0] HALF_V  = PW'(DEPTH / 2 + 1);

   logic [PW-1:0]     fill;
   logic [PW-1:0]     wnext;
   logic [ADDR_W-1:0] af_lvl;
   logic              empty_w;
   cfg_sel_e          sel;

   assign fill    = wptr - rptr_s;
   assign full_w  = fill[ADDR_W];
   assign empty_w = (fill == '0);
   assign half_w  = (fill >= HALF_V);
   assign alm_f   = (fill >= (DEPTH_V - {1'b0, af_lvl}));
   assign sel     = cfg_sel_e'(cfg_sel);
   assign mem_we  = wr_en && !cfg_wr && !full_w;
   assign wnext   = wptr + 1'b1;

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         wgray <= '0;
      end else if (mem_we) begin
         wptr  <= wnext;
         wgray <= wnext ^ (wnext >> 1);
      end
   end

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         ae_lvl <= ADDR_W'(ALM_DEFAULT);
         af_lvl <= ADDR_W'(ALM_DEFAULT);
         mode   <= '0;
      end else if (cfg_wr && empty_w) begin
         case (sel)
            SEL_AE_LVL: ae_lvl <= cfg_val;
            SEL_AF_LVL: af_lvl <= cfg_val;
            SEL_PARITY: mode   <= par_mode_t'(cfg_val[1:0]);
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl #(
   parameter int ADDR_W = 9
)(
   input  logic              rclk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              rt,
   input  logic [ADDR_W:0]   wptr_s,
   input  logic [ADDR_W-1:0] ae_lvl,
   output logic [ADDR_W:0]   rptr,
   output logic [ADDR_W:0]   rgray,
   output logic              empty_r,
   output logic              alm_e,
   output logic              rd_go
);
   localparam int PW = ADDR_W + 1;

   logic [PW-1:0] fill;
   logic [PW-1:0] rnext;

   assign fill    = wptr_s - rptr;
   assign empty_r = (fill == '0);
   assign alm_e   = (fill <= {1'b0, ae_lvl});
   assign rd_go   = rd_en && !rt && !empty_r;
   assign rnext   = rptr + 1'b1;

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rptr  <= '0;
         rgray <= '0;
      end else if (rt) begin
         rptr  <= '0;
         rgray <= '0;
      end else if (rd_go) begin
         rptr  <= rnext;
         rgray <= rnext ^ (rnext >> 1);
      end
   end
endmodule

// File: rtl/dcfifo_par.sv
`timescale 1ns/1ps
module dcfifo_par
   import dcf_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int BYTE_W      = 9,
   parameter int ADDR_W      = 9,
   parameter int SYNC_STAGES = 2,
   parameter int ALM_DEFAULT = 8,
   parameter bit PAR_EN      = 1'b1
)(
   input  logic                     wclk,
   input  logic                     rclk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     cfg_wr,
   input  logic [DATA_W-1:0]        din,
   input  logic                     rd_en,
   input  logic                     rt,
   output logic [DATA_W-1:0]        dout,
   output logic [DATA_W/BYTE_W-1:0] par_err,
   output logic                     bound_flag,
   output logic                     near_flag,
   output logic                     half_flag
);
   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;
   localparam int NBYTE = DATA_W / BYTE_W;

   // elaboration-time parameter checks
   if (DATA_W % BYTE_W != 0) begin : g_bad_byte
      $error("DATA_W must be a whole number of BYTE_W lanes");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end
   if (DATA_W < ADDR_W + CFG_SEL_W) begin : g_bad_cfg
      $error("DATA_W too narrow to carry a program word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ALM_DEFAULT >= DEPTH / 2) begin : g_bad_alm
      $error("ALM_DEFAULT must be below half the depth");
   end

   logic [PW-1:0]      wptr, wgray, rptr, rgray, wptr_s, rptr_s;
   logic               mem_we, full_w, alm_f, half_w;
   logic               empty_r, alm_e, rd_go;
   logic [ADDR_W-1:0]  ae_lvl;
   par_mode_t          mode;
   logic [DATA_W-1:0]  wr_word, rd_word;
   logic [NBYTE-1:0]   chk_err;
   logic [DATA_W-1:0]  mem [DEPTH];

   dcf_wr_ctl #(.ADDR_W(ADDR_W), .ALM_DEFAULT(ALM_DEFAULT)) u_wr (
      .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .cfg_wr(cfg_wr),
      .cfg_sel(din[DATA_W-1 -: CFG_SEL_W]), .cfg_val(din[ADDR_W-1:0]),
      .rptr_s(rptr_s), .wptr(wptr), .wgray(wgray), .mem_we(mem_we),
      .full_w(full_w), .alm_f(alm_f), .half_w(half_w),
      .ae_lvl(ae_lvl), .mode(mode));

   dcf_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
      .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .rt(rt),
      .wptr_s(wptr_s), .ae_lvl(ae_lvl), .rptr(rptr), .rgray(rgray),
      .empty_r(empty_r), .alm_e(alm_e), .rd_go(rd_go));

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wptr_s));

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rptr_s));

   dcf_par #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .PAR_EN(PAR_EN)) u_par (
      .gen_en(mode.gen), .chk_en(mode.chk), .wr_in(din), .wr_out(wr_word),
      .rd_word(rd_word), .err(chk_err));

   always_ff @(posedge wclk) begin
      if (mem_we) mem[wptr[ADDR_W-1:0]] <= wr_word;
   end

   assign rd_word = mem[rptr[ADDR_W-1:0]];

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         dout    <= '0;
         par_err <= '0;
      end else if (rd_go) begin
         dout    <= rd_word;
         par_err <= chk_err;
      end
   end

   assign bound_flag = empty_r | full_w;
   assign near_flag  = alm_e | alm_f;
   assign half_flag  = half_w;
endmodule

// File: rtl/dcf_chk.sv
`timescale 1ns/1ps
module dcf_chk #(
   parameter int PW     = 10,
   parameter int DATA_W = 18
)(
   input logic              wclk,
   input logic              rclk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              rt,
   input logic              full_w,
   input logic              half_w,
   input logic              empty_r,
   input logic              alm_e,
   input logic [PW-1:0]     wptr,
   input logic [PW-1:0]     rptr,
   input logic [PW-1:0]     wgray,
   input logic [DATA_W-1:0] dout
);
   // R2: a full buffer never advances the write pointer
   a_r2_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
      full_w |=> $stable(wptr));

   // R3: an empty buffer never advances the read pointer
   a_r3_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
      (empty_r && !rt) |=> $stable(rptr));

   // R3: without an accepted read the output register holds
   a_r3_dout_hold: assert property (@(posedge rclk) disable iff (!rst_n)
      (rt || !rd_en || empty_r) |=> $stable(dout));

   // R10: rewind lands on location zero
   a_r10_rewind: assert property (@(posedge rclk) disable iff (!rst_n)
      rt |=> (rptr == '0));

   // R5: a full buffer is always past half
   a_r5_half_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
      full_w |-> half_w);

   // R6: an empty buffer is always inside the almost-empty band
   a_r6_near_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
      empty_r |-> alm_e);

   // R1: the crossing pointer changes at most one bit per write edge
   a_r1_gray_step: assert property (@(posedge wclk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);
endmodule

bind dcfifo_par dcf_chk #(.PW(ADDR_W + 1), .DATA_W(DATA_W)) u_chk (
   .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .rt(rt),
   .full_w(full_w), .half_w(half_w), .empty_r(empty_r), .alm_e(alm_e),
   .wptr(wptr), .rptr(rptr), .wgray(wgray), .dout(dout));

// File: tb/dcfifo_par_bench.sv
`timescale 1ns/1ps
module dcfifo_par_bench;
   localparam int DEPTH = 512;
   localparam int NSTREAM = 1500;

   logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 1'b0, cfg_wr = 1'b0, rd_en = 1'b0, rt = 1'b0;
   logic [17:0] din = '0;
   logic [17:0] dout;
   logic [1:0]  par_err;
   logic        bound_flag, near_flag, half_flag;

   always #2.5 wclk = ~wclk;
   always #3.5 rclk = ~rclk;

   dcfifo_par u_dcfifo_par (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .cfg_wr(cfg_wr),
      .din(din), .rd_en(rd_en), .rt(rt), .dout(dout), .par_err(par_err),
      .bound_flag(bound_flag), .near_flag(near_flag), .half_flag(half_flag));

   int          n_vec = 0, n_bad = 0;
   logic [17:0] q[$];
   logic [17:0] saved[$];
   logic [17:0] last_rd = '0;
   bit          gen_on = 0, chk_on = 0;
   int          ae_m = 8, af_m = 8;
   int          wr_tot = 0, rd_tot = 0;
   bit          wdone = 0;
   int          seed_dummy;

   function automatic logic [17:0] with_par(input logic [17:0] d);
      logic [17:0] r;
      r = d;
      r[8]  = ^d[7:0];
      r[17] = ^d[16:9];
      return r;
   endfunction

   function automatic logic [1:0] err_of(input logic [17:0] d);
      return chk_on ? {^d[17:9], ^d[8:0]} : 2'b00;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (8) @(negedge rclk);
      repeat (2) @(negedge wclk);
   endtask

   task automatic check_flags(input string tag);
      int c;
      c = q.size();
      check({tag, " bound_flag"}, 32'(bound_flag), 32'(c == 0 || c == DEPTH));
      check({tag, " near_flag"},  32'(near_flag),  32'(c <= ae_m || c >= DEPTH - af_m));
      check({tag, " half_flag"},  32'(half_flag),  32'(c >= 257));
   endtask

   task automatic write_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge wclk);
         wr_en = 1'b1;
         din   = 18'($urandom);
         q.push_back(gen_on ? with_par(din) : din);
      end
      @(negedge wclk);
      wr_en = 1'b0;
   endtask

   task automatic read_n(input int n, input string tag);
      logic [17:0] e;
      bit pend;
      pend = 0;
      e = '0;
      for (int i = 0; i <= n; i++) begin
         @(negedge rclk);
         if (pend) begin
            check({tag, " data"}, 32'(dout), 32'(e));
            check({tag, " par_err"}, 32'(par_err), 32'(err_of(e)));
            last_rd = e;
         end
         if (i < n) begin
            rd_en = 1'b1;
            e = q.pop_front();
            pend = 1;
         end else begin
            rd_en = 1'b0;
            pend = 0;
         end
      end
   endtask

   task automatic cfg(input logic [1:0] sel, input logic [8:0] val);
      @(negedge wclk);
      cfg_wr = 1'b1;
      din    = {sel, 7'd0, val};
      @(negedge wclk);
      cfg_wr = 1'b0;
   endtask

   task automatic do_reset();
      wr_en = 0; rd_en = 0; cfg_wr = 0; rt = 0;
      rst_n = 1'b0;
      repeat (3) @(negedge wclk);
      rst_n = 1'b1;
      q.delete();
      ae_m = 8; af_m = 8; gen_on = 0; chk_on = 0;
      settle();
   endtask

   task automatic stream();
      wr_tot = 0; rd_tot = 0; wdone = 0;
      fork
         begin
            while (wr_tot < NSTREAM) begin
               @(negedge wclk);
               if (($urandom % 3) != 0 && (wr_tot - rd_tot) < 500) begin
                  wr_en = 1'b1;
                  din   = 18'($urandom);
                  q.push_back(gen_on ? with_par(din) : din);
                  wr_tot++;
               end else begin
                  wr_en = 1'b0;
               end
            end
            @(negedge wclk);
            wr_en = 1'b0;
            #100;
            wdone = 1;
         end
         begin
            logic [17:0] e;
            bit pend;
            int avail;
            pend = 0;
            e = '0;
            while (rd_tot < NSTREAM || pend) begin
               @(negedge rclk);
               if (pend) begin
                  check("R1 stream data", 32'(dout), 32'(e));
                  check("R9 stream par_err", 32'(par_err), 32'(err_of(e)));
                  pend = 0;
               end
               avail = wr_tot - rd_tot;
               if (rd_tot < NSTREAM && (avail > 8 || (wdone && avail > 0))
                   && ($urandom % 4) != 0) begin
                  rd_en = 1'b1;
                  e = q.pop_front();
                  rd_tot++;
                  pend = 1;
               end else begin
                  rd_en = 1'b0;
               end
            end
            rd_en = 1'b0;
         end
      join
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      seed_dummy = $urandom(32'h5eed_1234);
      do_reset();

      // R11 reset state
      check("R11 reset dout", 32'(dout), 32'd0);
      check("R11 reset par_err", 32'(par_err), 32'd0);
      check_flags("R11 reset R4 R6");

      // R1 small transfer
      write_n(5); settle();
      check_flags("R6 count 5");
      read_n(5, "R1 short burst"); settle();
      check_flags("R4 empty again");

      // stepping the fill level across every boundary
      write_n(8); settle();   check_flags("R6 near at 8");
      write_n(1); settle();   check_flags("R6 near off at 9");
      write_n(247); settle(); check_flags("R5 half off at 256");
      write_n(1); settle();   check_flags("R5 half on at 257");
      write_n(246); settle(); check_flags("R6 near off at 503");
      write_n(1); settle();   check_flags("R6 near on at 504");
      write_n(8); settle();   check_flags("R4 full at 512");

      // R2 extra write while full
      @(negedge wclk); wr_en = 1'b1; din = 18'h2A5A5;
      @(negedge wclk); wr_en = 1'b0;
      settle();
      check_flags("R2 full after extra write");
      read_n(DEPTH, "R2 order kept"); settle();
      check_flags("R4 empty after drain");

      // R3 extra read while empty
      @(negedge rclk); rd_en = 1'b1;
      @(negedge rclk); rd_en = 1'b0;
      settle();
      check("R3 dout held", 32'(dout), 32'(last_rd));
      check_flags("R3 still empty");

      // R7 program distances while empty
      cfg(2'd0, 9'd20); ae_m = 20;
      cfg(2'd1, 9'd30); af_m = 30;
      settle();
      check_flags("R7 empty after program");
      write_n(20); settle(); check_flags("R7 ae level at 20");
      write_n(1);  settle(); check_flags("R7 ae level at 21");
      cfg(2'd0, 9'd100); settle();
      check_flags("R7 ignored when not empty");
      write_n(460); settle(); check_flags("R7 af level at 481");
      write_n(1);   settle(); check_flags("R7 af level at 482");
      read_n(482, "R7 program word not stored"); settle();

      // R8 parity generation
      cfg(2'd2, 9'd1); gen_on = 1; chk_on = 0;
      write_n(30); settle();
      read_n(30, "R8 generated parity"); settle();

      // R9 parity check on raw random words
      cfg(2'd2, 9'd2); gen_on = 0; chk_on = 1;
      write_n(40); settle();
      read_n(40, "R9 checked parity"); settle();

      // generate and check together, then a random stream
      cfg(2'd2, 9'd3); gen_on = 1; chk_on = 1;
      settle();
      stream();
      settle();
      check_flags("R4 empty after stream");

      // R11 reset with data stored
      write_n(10); settle();
      do_reset();
      check("R11 reset dout with data", 32'(dout), 32'd0);
      check_flags("R11 reset empties");

      // R10 retransmit
      write_n(40);
      saved = q;
      settle();
      read_n(40, "R1 before rewind"); settle();
      @(negedge rclk); rt = 1'b1;
      @(negedge rclk); rt = 1'b0;
      settle();
      q = saved;
      check_flags("R10 count after rewind");
      read_n(40, "R10 replay"); settle();
      check_flags("R10 empty after replay");

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule